// File: doc/BRIEF.md
# Processor Status Word Access Unit

This unit owns the processor's 32-bit current status word: the four condition flags, the two interrupt-disable bits, the instruction-state bit and the five-bit operating-mode field. It also holds one saved status word for each exception mode. Instructions read or write these registers through an operation select, a target select and a 32-bit operand. Every write passes through a mask. The mask depends on whether the operand is an immediate, whether only the flags are addressed, and whether the current mode is privileged.

A separate exception-entry port moves the processor into an exception mode. In one clock it copies the current word into that mode's saved register, sets the new mode and raises the interrupt-disable bits. This port takes priority over any instruction access in the same cycle. The read value is combinational. Writes take effect at the next rising clock edge.

Top module: `psr_access_unit`

## Requirements
- R1: After reset the current word is 0x000000D3: mode 10011 in bits 4:0, I (bit 7) and F (bit 6) set, T (bit 5), the flags (bits 31:28) and the reserved bits cleared. Every saved word reads 0.
- R2: With op_i = 01 (read), rdata_o returns the whole current word when target_i = 0 and the whole saved word of the current mode when target_i = 1. For any other op, rdata_o is 0.
- R3: With op_i = 10 (full write) in a privileged mode (any mode other than 10000), the target takes operand bits 31:28 and 7:0 and keeps its other bits.
- R4: With op_i = 11 (flags write), only bits 31:28 of the target take the operand value.
- R5: When imm_i is high on either write op, only operand bits 31:28 reach the target's flags, and bits 27:0 are unchanged.
- R6: In User mode (10000), a write of either kind to the current word changes only bits 31:28. The mode, I, F and T bits keep their values.
- R7: Bits 27:8 of the current word and of every saved word are never changed by an instruction write.
- R8: In User mode (10000), System mode (11111) or any mode encoding without a saved bank, a read of the saved target returns 0 and a write to it changes nothing.
- R9: On exc_valid_i with exc_mode_i one of 10001, 10010, 10011, 10111, 11011, the saved word of that mode takes the old current word. The current word's mode becomes exc_mode_i and I is set. F is set as well when exc_mode_i is 10001. All other bits are kept. Any other exc_mode_i value is ignored.
- R10: When an accepted exception entry and an instruction write fall in the same cycle, the instruction write is dropped entirely.
- R11: Each of the five exception modes has its own saved word. A saved-target access uses the bank of the current mode only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | 00 idle, 01 read, 10 full write, 11 flags write |
| target_i | input | 1 | 0 current word, 1 saved word of current mode |
| operand_i | input | 32 | Write data or immediate |
| imm_i | input | 1 | Operand is an immediate; only its top four bits are written |
| exc_valid_i | input | 1 | Exception-entry request |
| exc_mode_i | input | 5 | Mode entered on exception |
| rdata_o | output | 32 | Read value |
| cpsr_o | output | 32 | Current status word |

## Verification
An exception entry and an instruction write can occur in the same cycle, and both target the current word or a saved bank. The bench enters Supervisor mode and then asserts exc_valid_i for each of eight mode encodings. In the same cycle it issues an all-ones full write, once to the current word and once to the saved word. When the exception mode has a bank, the bench expects only the exception's effect and reads back both the new current word and the saved bank. When the exception is ignored, the instruction write must land as if it had arrived alone.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W      = 32;
  localparam int MODE_W     = 5;
  localparam int FLAG_W     = 4;
  localparam int BIT_I      = 7;
  localparam int BIT_F      = 6;
  localparam int NUM_BANKS  = 5;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  localparam logic [PSR_W-1:0] FLAG_MASK  = {{FLAG_W{1'b1}}, {(PSR_W-FLAG_W){1'b0}}};
  localparam logic [PSR_W-1:0] CTRL_MASK  = {{(PSR_W-8){1'b0}}, 8'hFF};
  localparam logic [PSR_W-1:0] RESET_WORD = {{(PSR_W-8){1'b0}}, 8'hD3};

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WR    = 2'b10,
    OP_WR_FL = 2'b11
  } op_e;

  typedef struct packed {
    logic                  hit;
    logic [BANK_IDX_W-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] mode);
    bank_sel_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case (mode)
      MODE_FIQ: s.idx = BANK_IDX_W'(0);
      MODE_IRQ: s.idx = BANK_IDX_W'(1);
      MODE_SVC: s.idx = BANK_IDX_W'(2);
      MODE_ABT: s.idx = BANK_IDX_W'(3);
      MODE_UND: s.idx = BANK_IDX_W'(4);
      default:  s.hit = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/psr_write_mask.sv
module psr_write_mask
  import psr_pkg::*;
(
  input  logic [1:0]       op_i,
  input  logic             imm_i,
  input  logic             priv_i,
  output logic [PSR_W-1:0] mask_o
);
  always_comb begin
    mask_o = '0;
    if (op_i == OP_WR || op_i == OP_WR_FL) begin
      mask_o = FLAG_MASK;
      // control byte only for register-form full writes while privileged
      if (op_i == OP_WR && !imm_i && priv_i) mask_o = FLAG_MASK | CTRL_MASK;
    end
  end

  always_comb begin
    if (op_i == OP_WR_FL || imm_i)
      assert_flag_only_R4: assert ((mask_o & ~FLAG_MASK) == '0);
    assert_reserved_mask_R7: assert ((mask_o & ~(FLAG_MASK | CTRL_MASK)) == '0);
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  exc_we_i,
  input  logic [BANK_IDX_W-1:0] exc_idx_i,
  input  logic [PSR_W-1:0]      exc_data_i,
  input  logic                  ins_we_i,
  input  logic [BANK_IDX_W-1:0] ins_idx_i,
  input  logic [PSR_W-1:0]      ins_mask_i,
  input  logic [PSR_W-1:0]      ins_data_i,
  input  logic [BANK_IDX_W-1:0] rd_idx_i,
  output logic [PSR_W-1:0]      rd_data_o
);
  logic [PSR_W-1:0]     bank_all [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PSR_W-1:0] q;
    logic             exc_hit, ins_hit;
    assign exc_hit    = exc_we_i && (exc_idx_i == BANK_IDX_W'(b));
    assign ins_hit    = ins_we_i && (ins_idx_i == BANK_IDX_W'(b));
    assign bank_we[b] = exc_hit || ins_hit;
    assign bank_all[b] = q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (exc_hit) q <= exc_data_i;
      else if (ins_hit) q <= (q & ~ins_mask_i) | (ins_data_i & ins_mask_i);
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (32'(rd_idx_i) < NUM_BANKS) rd_data_o = bank_all[rd_idx_i];
  end

  assert_one_bank_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we));
  assert_bank_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_we_i && 32'(exc_idx_i) < NUM_BANKS) |=> bank_all[$past(exc_idx_i)] == $past(exc_data_i));
endmodule

// File: rtl/psr_access_unit.sv
module psr_access_unit
  import psr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic              target_i,
  input  logic [PSR_W-1:0]  operand_i,
  input  logic              imm_i,
  input  logic              exc_valid_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  output logic [PSR_W-1:0]  rdata_o,
  output logic [PSR_W-1:0]  cpsr_o
);
  logic [PSR_W-1:0] cpsr_q, cpsr_d;
  logic [PSR_W-1:0] mask_cur, mask_sav, sav_rd;
  logic             priv, is_wr, exc_take, cur_we, sav_we;
  bank_sel_t        cur_bank, exc_bank;

  assign priv     = cpsr_q[MODE_W-1:0] != MODE_USR;
  assign cur_bank = bank_of(cpsr_q[MODE_W-1:0]);
  assign exc_bank = bank_of(exc_mode_i);
  assign exc_take = exc_valid_i && exc_bank.hit;
  assign is_wr    = (op_i == OP_WR) || (op_i == OP_WR_FL);
  assign cur_we   = is_wr && !target_i && !exc_take;
  assign sav_we   = is_wr && target_i && cur_bank.hit && !exc_take;

  psr_write_mask u_mask_cur (
    .op_i   (op_i),
    .imm_i  (imm_i),
    .priv_i (priv),
    .mask_o (mask_cur)
  );

  // a saved bank exists only in privileged modes
  psr_write_mask u_mask_sav (
    .op_i   (op_i),
    .imm_i  (imm_i),
    .priv_i (1'b1),
    .mask_o (mask_sav)
  );

  psr_saved_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_we_i   (exc_take),
    .exc_idx_i  (exc_bank.idx),
    .exc_data_i (cpsr_q),
    .ins_we_i   (sav_we),
    .ins_idx_i  (cur_bank.idx),
    .ins_mask_i (mask_sav),
    .ins_data_i (operand_i),
    .rd_idx_i   (cur_bank.idx),
    .rd_data_o  (sav_rd)
  );

  always_comb begin
    cpsr_d = cpsr_q;
    if (exc_take) begin
      cpsr_d[MODE_W-1:0] = exc_mode_i;
      cpsr_d[BIT_I]      = 1'b1;
      if (exc_mode_i == MODE_FIQ) cpsr_d[BIT_F] = 1'b1;
    end else if (cur_we) begin
      cpsr_d = (cpsr_q & ~mask_cur) | (operand_i & mask_cur);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpsr_q <= RESET_WORD;
    else         cpsr_q <= cpsr_d;
  end

  always_comb begin
    rdata_o = '0;
    if (op_i == OP_READ) begin
      if (!target_i)         rdata_o = cpsr_q;
      else if (cur_bank.hit) rdata_o = sav_rd;
    end
  end

  assign cpsr_o = cpsr_q;

  always_comb begin
    if (op_i == OP_READ && target_i && !cur_bank.hit)
      assert_saved_zero_R8: assert (rdata_o == '0);
  end

  assert_reserved_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cpsr_q[27:8] == $past(cpsr_q[27:8]));
  assert_user_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && !target_i && !exc_valid_i && cpsr_q[MODE_W-1:0] == MODE_USR)
    |=> cpsr_q[27:0] == $past(cpsr_q[27:0]));
  assert_flags_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR_FL && !target_i && !exc_valid_i) |=> cpsr_q[27:0] == $past(cpsr_q[27:0]));
  assert_exc_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take |=> (cpsr_q[MODE_W-1:0] == $past(exc_mode_i)) && cpsr_q[BIT_I]);
  assert_exc_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take && is_wr) |=> cpsr_q[31:28] == $past(cpsr_q[31:28]));
endmodule

// File: tb/psr_access_unit_test.sv
module psr_access_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        target_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        imm_i = 1'b0;
  logic        exc_valid_i = 1'b0;
  logic [4:0]  exc_mode_i = '0;
  logic [31:0] rdata_o, cpsr_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cpsr;
  logic [31:0] m_sav [5];

  psr_access_unit uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] op, input logic imm, input logic priv);
    if (op == 2'b10 && !imm && priv) return 32'hF000_00FF;
    return 32'hF000_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // update the model, apply one cycle, check current word and both reads
  task automatic cyc(input logic [1:0] op, input logic tgt, input logic [31:0] opnd,
                     input logic imm, input logic exc, input logic [4:0] em, input string req);
    int cb, eb;
    logic [31:0] mk;
    cb = bidx(m_cpsr[4:0]);
    eb = bidx(em);
    op_i = op; target_i = tgt; operand_i = opnd; imm_i = imm;
    exc_valid_i = exc; exc_mode_i = em;
    if (exc && eb >= 0) begin
      m_sav[eb] = m_cpsr;
      m_cpsr[4:0] = em;
      m_cpsr[7] = 1'b1;
      if (em == 5'b10001) m_cpsr[6] = 1'b1;
    end else if (op[1]) begin
      if (!tgt) begin
        mk = wmask(op, imm, m_cpsr[4:0] != 5'b10000);
        m_cpsr = (m_cpsr & ~mk) | (opnd & mk);
      end else if (cb >= 0) begin
        mk = wmask(op, imm, 1'b1);
        m_sav[cb] = (m_sav[cb] & ~mk) | (opnd & mk);
      end
    end
    @(negedge clk_i);
    op_i = 2'b00; exc_valid_i = 1'b0; imm_i = 1'b0;
    chk(req, cpsr_o, m_cpsr);
    chk("R7", {12'h0, cpsr_o[27:8]}, 32'h0);
    #1 chk("R2", rdata_o, 32'h0);
    op_i = 2'b01; target_i = 1'b0;
    #1 chk("R2", rdata_o, m_cpsr);
    target_i = 1'b1;
    cb = bidx(m_cpsr[4:0]);
    #1 chk(cb < 0 ? "R8" : "R11", rdata_o, cb < 0 ? 32'h0 : m_sav[cb]);
    op_i = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0]  modes [8];
    logic [31:0] pats [4];
    modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b11010};
    pats  = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
    m_cpsr = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sav[i] = '0;

    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", cpsr_o, 32'h0000_00D3);
    op_i = 2'b01; target_i = 1'b1;
    #1 chk("R1", rdata_o, 32'h0);
    op_i = 2'b00;

    // sweep: mode x op x target x imm x pattern
    for (int mi = 0; mi < 8; mi++)
      for (int op = 2; op < 4; op++)
        for (int t = 0; t < 2; t++)
          for (int im = 0; im < 2; im++)
            for (int p = 0; p < 4; p++) begin
              string req;
              cyc(2'b00, 1'b0, '0, 1'b0, 1'b1, 5'b10011, "R9");
              cyc(2'b10, 1'b0, {24'h0, 3'b110, modes[mi]}, 1'b0, 1'b0, 5'b0, "R3");
              if (im != 0)                  req = "R5";
              else if (t != 0)              req = (bidx(modes[mi]) < 0) ? "R8" : "R11";
              else if (modes[mi] == 5'b10000) req = "R6";
              else if (op == 3)             req = "R4";
              else                          req = "R3";
              cyc(2'(op), t[0], pats[p], im[0], 1'b0, 5'b0, req);
            end

    // exception entry colliding with an instruction write
    for (int mi = 0; mi < 8; mi++)
      for (int t = 0; t < 2; t++) begin
        cyc(2'b00, 1'b0, '0, 1'b0, 1'b1, 5'b10011, "R9");
        cyc(2'b10, 1'b0, 32'h3000_00D3, 1'b0, 1'b0, 5'b0, "R3");
        cyc(2'b10, t[0], 32'hFFFF_FFFF, 1'b0, 1'b1, modes[mi], "R10");
      end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule